// File: doc/BRIEF.md
# Host-to-Coprocessor Byte Mailbox

This block is a one-byte mailbox between a host I/O bus and an on-board coprocessor. The host sees a four-byte window. Offset 2 is a control port on write and a status port on read. Offset 3 is the data port. Offsets 0 and 1 belong to a MIDI path that lives outside this block.

A control write picks one of two modes. In host mode, a host write to the data port fills a one-byte command slot, which the coprocessor drains over a valid/ready handshake. The coprocessor posts reply bytes with a strobe into a one-byte reply slot. The host reads the reply from the data port.

The status byte carries three things:
- a ready-to-send flag;
- a reply-available flag;
- a mode indicator.

A pending reply also drives the host-interface interrupt request.

A typical exchange runs as follows. The host selects host mode and polls until it may send. It writes an opcode (for example 0x82, a board-type query) followed by up to two parameter bytes. It then waits for a reply byte such as the 0x80 acknowledge, and finally writes 0x03 to hand the board back to MIDI use.

Top module: `hostmbox_top`

## Requirements
- R1: After reset the block is in MIDI mode, `host_irq` and `cop_cmd_valid` are low, and a status read returns 0x02.
- R2: A control write of 0x00 to offset 2 selects host mode, and a write of 0x03 selects MIDI mode. Every other value leaves the mode unchanged. Status bit 7 reads 1 in host mode and 0 in MIDI mode.
- R3: In host mode, a data-port write while status bit 1 is set loads the byte. From the next cycle on, `cop_cmd_valid` is high, `cop_cmd_data` holds the byte, and status bit 1 reads 0.
- R4: A data-port write while status bit 1 is clear is ignored, and the held command byte stays unchanged.
- R5: A cycle with both `cop_cmd_valid` and `cop_cmd_ready` high consumes the byte. On the next cycle `cop_cmd_valid` is low and status bit 1 reads 1.
- R6: A `cop_rsp_strobe` while no reply is pending captures `cop_rsp_data`. From the next cycle on, status bit 0 and `host_irq` are both set.
- R7: A `cop_rsp_strobe` while a reply is already pending is dropped, and the first byte is kept.
- R8: In host mode, a read of the data port puts the reply byte on `hst_rdata` one cycle later and clears both status bit 0 and `host_irq`.
- R9: In MIDI mode, data-port reads return 0x00 and leave the pending reply in place. Data-port writes in MIDI mode load nothing.
- R10: Reads of offsets 0 and 1 return 0x00, and writes to them change neither the mode nor the command slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr_en | input | 1 | Host write strobe, one cycle per access |
| hst_rd_en | input | 1 | Host read strobe, one cycle per access |
| hst_addr | input | AW | Window offset |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Registered host read data, valid the cycle after a read |
| host_irq | output | 1 | Host-interface interrupt request, high while a reply is pending |
| cop_cmd_valid | output | 1 | Command byte available to the coprocessor |
| cop_cmd_ready | input | 1 | Coprocessor takes the command byte |
| cop_cmd_data | output | DW | Command byte |
| cop_rsp_strobe | input | 1 | Coprocessor posts a reply byte |
| cop_rsp_data | input | DW | Reply byte |

## Verification
The hardest situation to reach from the ports is a second reply, or a second host write, that lands while the first byte is still held. It takes a deliberate ordering of the two sides: the bench posts a reply, then a different reply before the host reads, and likewise writes the complemented byte before the coprocessor handshake. Every one of the 256 byte values is driven through both paths this way. Mode isolation is reached by leaving a reply pending across a switch to MIDI mode and back, which shows the reply survives untouched.

// File: rtl/hostmbox_pkg.sv
package hostmbox_pkg;

  typedef enum logic {
    MODE_MIDI = 1'b0,
    MODE_HOST = 1'b1
  } mbx_mode_e;

  typedef struct packed {
    logic data_wr;
    logic data_rd;
  } mbx_strobe_t;

endpackage

// File: rtl/hostmbox_decode.sv
module hostmbox_decode
  import hostmbox_pkg::*;
#(
  parameter int unsigned AW        = 2,
  parameter int unsigned DW        = 8,
  parameter logic [AW-1:0] CTL_OFS  = 2,
  parameter logic [AW-1:0] DATA_OFS = 3,
  parameter logic [DW-1:0] HOST_CODE = 8'h00,
  parameter logic [DW-1:0] MIDI_CODE = 8'h03
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output mbx_mode_e     mode,
  output mbx_strobe_t   strb
);

  logic ctl_hit;
  logic data_hit;

  assign ctl_hit  = (addr == CTL_OFS);
  assign data_hit = (addr == DATA_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_MIDI;
    end else if (wr_en && ctl_hit) begin
      if (wdata == HOST_CODE) begin
        mode <= MODE_HOST;
      end else if (wdata == MIDI_CODE) begin
        mode <= MODE_MIDI;
      end
    end
  end

  always_comb begin
    strb.data_wr = wr_en && data_hit && (mode == MODE_HOST);
    strb.data_rd = rd_en && data_hit && (mode == MODE_HOST);
  end

endmodule

// File: rtl/hostmbox_txslot.sv
module hostmbox_txslot #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          space,
  output logic          valid,
  input  logic          ready,
  output logic [DW-1:0] data
);

  logic full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (!full) begin
      if (push) begin
        full <= 1'b1;
        data <= push_data;
      end
    end else if (ready) begin
      full <= 1'b0;
    end
  end

  assign valid = full;
  assign space = !full;

endmodule

// File: rtl/hostmbox_rxslot.sv
module hostmbox_rxslot #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] sdata,
  input  logic          pop,
  output logic          avail,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      avail <= 1'b0;
      data  <= '0;
    end else if (!avail) begin
      if (strobe) begin
        avail <= 1'b1;
        data  <= sdata;
      end
    end else if (pop) begin
      avail <= 1'b0;
    end
  end

endmodule

// File: rtl/hostmbox_top.sv
module hostmbox_top
  import hostmbox_pkg::*;
#(
  parameter int unsigned AW        = 2,
  parameter int unsigned DW        = 8,
  parameter logic [AW-1:0] CTL_OFS  = 2,
  parameter logic [AW-1:0] DATA_OFS = 3,
  parameter logic [DW-1:0] HOST_CODE = 8'h00,
  parameter logic [DW-1:0] MIDI_CODE = 8'h03
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hst_wr_en,
  input  logic          hst_rd_en,
  input  logic [AW-1:0] hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          host_irq,
  output logic          cop_cmd_valid,
  input  logic          cop_cmd_ready,
  output logic [DW-1:0] cop_cmd_data,
  input  logic          cop_rsp_strobe,
  input  logic [DW-1:0] cop_rsp_data
);

  localparam int unsigned ST_RX   = 0;
  localparam int unsigned ST_TX   = 1;
  localparam int unsigned ST_MODE = DW - 1;

  mbx_mode_e   mode;
  mbx_strobe_t strb;
  logic        tx_space;
  logic        rx_avail;
  logic [DW-1:0] rx_data;
  logic [DW-1:0] status;

  hostmbox_decode #(
    .AW(AW), .DW(DW), .CTL_OFS(CTL_OFS), .DATA_OFS(DATA_OFS),
    .HOST_CODE(HOST_CODE), .MIDI_CODE(MIDI_CODE)
  ) decode_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (hst_wr_en),
    .rd_en (hst_rd_en),
    .addr  (hst_addr),
    .wdata (hst_wdata),
    .mode  (mode),
    .strb  (strb)
  );

  hostmbox_txslot #(.DW(DW)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .push      (strb.data_wr),
    .push_data (hst_wdata),
    .space     (tx_space),
    .valid     (cop_cmd_valid),
    .ready     (cop_cmd_ready),
    .data      (cop_cmd_data)
  );

  hostmbox_rxslot #(.DW(DW)) rx_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (cop_rsp_strobe),
    .sdata  (cop_rsp_data),
    .pop    (strb.data_rd),
    .avail  (rx_avail),
    .data   (rx_data)
  );

  always_comb begin
    status          = '0;
    status[ST_RX]   = rx_avail;
    status[ST_TX]   = tx_space;
    status[ST_MODE] = (mode == MODE_HOST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata <= '0;
    end else if (hst_rd_en) begin
      if (hst_addr == CTL_OFS) begin
        hst_rdata <= status;
      end else if (strb.data_rd) begin
        hst_rdata <= rx_data;
      end else begin
        hst_rdata <= '0;
      end
    end
  end

  assign host_irq = rx_avail;

endmodule

// File: rtl/hostmbox_chk.sv
module hostmbox_chk #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] DATA_OFS = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          hst_wr_en,
  input logic          hst_rd_en,
  input logic [AW-1:0] hst_addr,
  input logic          host_irq,
  input logic          cop_cmd_valid,
  input logic          cop_cmd_ready,
  input logic [DW-1:0] cop_cmd_data,
  input logic          cop_rsp_strobe
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!cop_cmd_valid && !host_irq)); // R1

  AST_CMD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(cop_cmd_valid) |-> $past(hst_wr_en && hst_addr == DATA_OFS)); // R3

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (cop_cmd_valid && !cop_cmd_ready) |=> (cop_cmd_valid && $stable(cop_cmd_data))); // R4

  AST_CMD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (cop_cmd_valid && cop_cmd_ready) |=> !cop_cmd_valid); // R5

  AST_IRQ_ON_REPLY: assert property (@(posedge clk) disable iff (rst)
    (cop_rsp_strobe && !host_irq) |=> host_irq); // R6

  AST_IRQ_KEPT: assert property (@(posedge clk) disable iff (rst)
    (host_irq && !(hst_rd_en && hst_addr == DATA_OFS)) |=> host_irq); // R7

  AST_IRQ_CLEAR_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(host_irq) |-> $past(hst_rd_en && hst_addr == DATA_OFS)); // R8

endmodule

bind hostmbox_top hostmbox_chk #(.AW(AW), .DW(DW), .DATA_OFS(DATA_OFS)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .hst_wr_en      (hst_wr_en),
  .hst_rd_en      (hst_rd_en),
  .hst_addr       (hst_addr),
  .host_irq       (host_irq),
  .cop_cmd_valid  (cop_cmd_valid),
  .cop_cmd_ready  (cop_cmd_ready),
  .cop_cmd_data   (cop_cmd_data),
  .cop_rsp_strobe (cop_rsp_strobe)
);

// File: tb/hostmbox_top_tb_top.sv
`timescale 1ns/1ps
module hostmbox_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hst_wr_en = 1'b0;
  logic       hst_rd_en = 1'b0;
  logic [1:0] hst_addr = '0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] hst_rdata;
  logic       host_irq;
  logic       cop_cmd_valid;
  logic       cop_cmd_ready = 1'b0;
  logic [7:0] cop_cmd_data;
  logic       cop_rsp_strobe = 1'b0;
  logic [7:0] cop_rsp_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  hostmbox_top dut_i (
    .clk(clk), .rst(rst),
    .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .host_irq(host_irq),
    .cop_cmd_valid(cop_cmd_valid), .cop_cmd_ready(cop_cmd_ready),
    .cop_cmd_data(cop_cmd_data), .cop_rsp_strobe(cop_rsp_strobe),
    .cop_rsp_data(cop_rsp_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_rd_en = 1'b1; hst_addr = a;
    @(negedge clk);
    hst_rd_en = 1'b0;
    d = hst_rdata;
  endtask

  task automatic cop_take();
    @(negedge clk);
    cop_cmd_ready = 1'b1;
    @(negedge clk);
    cop_cmd_ready = 1'b0;
  endtask

  task automatic cop_reply(input logic [7:0] d);
    @(negedge clk);
    cop_rsp_strobe = 1'b1; cop_rsp_data = d;
    @(negedge clk);
    cop_rsp_strobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {7'd0, host_irq}, 8'h00);
    check("R1 valid", {7'd0, cop_cmd_valid}, 8'h00);
    hread(2'd2, r);
    check("R1 status", r, 8'h02);

    // R2 mode control sweep over every control value
    for (int v = 0; v < 256; v++) begin
      hwrite(2'd2, 8'h00);
      hwrite(2'd2, 8'(v));
      hread(2'd2, r);
      check("R2 from host", {7'd0, r[7]}, (v == 3) ? 8'h00 : 8'h01);
      hwrite(2'd2, 8'h03);
      hwrite(2'd2, 8'(v));
      hread(2'd2, r);
      check("R2 from midi", {7'd0, r[7]}, (v == 0) ? 8'h01 : 8'h00);
    end

    // R10 MIDI-side offsets are inert
    hwrite(2'd2, 8'h03);
    hwrite(2'd1, 8'h00);
    hwrite(2'd0, 8'h00);
    hread(2'd2, r);
    check("R10 mode kept", r, 8'h02);
    hread(2'd0, r);
    check("R10 read off0", r, 8'h00);
    hread(2'd1, r);
    check("R10 read off1", r, 8'h00);
    hwrite(2'd2, 8'h00);
    hwrite(2'd0, 8'h5C);
    hwrite(2'd1, 8'h5C);
    check("R10 no cmd", {7'd0, cop_cmd_valid}, 8'h00);

    // R3 R4 R5 command path, all byte values, host mode
    for (int v = 0; v < 256; v++) begin
      hwrite(2'd3, 8'(v));
      check("R3 valid", {7'd0, cop_cmd_valid}, 8'h01);
      check("R3 data", cop_cmd_data, 8'(v));
      hread(2'd2, r);
      check("R3 status", r, 8'h80);
      hwrite(2'd3, ~8'(v));
      check("R4 held", cop_cmd_data, 8'(v));
      cop_take();
      check("R5 valid low", {7'd0, cop_cmd_valid}, 8'h00);
      hread(2'd2, r);
      check("R5 status", r, 8'h82);
    end

    // R6 R7 R8 reply path, all byte values
    for (int v = 0; v < 256; v++) begin
      cop_reply(8'(v));
      check("R6 irq", {7'd0, host_irq}, 8'h01);
      hread(2'd2, r);
      check("R6 status", r, 8'h83);
      cop_reply(8'(v) ^ 8'h5A);
      hread(2'd3, r);
      check("R7 R8 data", r, 8'(v));
      check("R8 irq", {7'd0, host_irq}, 8'h00);
      hread(2'd2, r);
      check("R8 status", r, 8'h82);
    end

    // R9 MIDI mode isolation
    cop_reply(8'h33);
    hwrite(2'd2, 8'h03);
    hread(2'd3, r);
    check("R9 read zero", r, 8'h00);
    check("R9 irq kept", {7'd0, host_irq}, 8'h01);
    hwrite(2'd3, 8'h44);
    check("R9 no cmd", {7'd0, cop_cmd_valid}, 8'h00);
    hwrite(2'd2, 8'h00);
    hread(2'd3, r);
    check("R9 reply kept", r, 8'h33);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule